// File: doc/BRIEF.md
# Keyboard Character Receive Buffer

This block sits between a character source, such as a serial keyboard decoder or a UART receiver, and a processor that polls for input. Each decoded 8-bit character arrives as a byte with a one-cycle strobe. The block writes it into a small circular store indexed by a write pointer and a read pointer. Whenever the two pointers differ, the store holds unread characters, and an empty flag reports that state to the processor.

The processor reads with a level handshake. It raises a request line. The block answers by asserting a completion line, and the oldest stored character appears on the data output. The processor must drop its request before it can read again. A request that is held high therefore takes exactly one character, and no character is returned twice or skipped.

If the processor raises its request while nothing is stored, completion waits until a character arrives. A character that arrives while all sixteen slots are occupied is discarded, and a sticky overflow flag records the loss. The empty flag, the completion line and the character are also packed into one 10-bit status word, so the processor can capture all three with a single input-port read.

Top module: `kbd_rx_fifo`

## Requirements
- R1: After a synchronous reset, `buf_empty` is 1, `rd_done` is 0 and `ovf_sticky` is 0. Reset also clears both pointers.
- R2: A cycle with `in_stb` high stores `in_byte` unless the store is full. `buf_empty` reads 0 from the cycle after that clock edge.
- R3: Characters are delivered in the order they arrived.
- R4: When `rd_req` is high and the store is not empty, `rd_done` rises on the next clock edge with the oldest character on `rd_byte`. Both stay unchanged while `rd_req` stays high.
- R5: Each high period of `rd_req` consumes at most one character. Holding `rd_req` high never consumes a second one. `rd_done` is 0 in the cycle after any cycle in which `rd_req` was low.
- R6: If `rd_req` is raised while the store is empty, `rd_done` stays 0 until a character has been stored. That character is then delivered.
- R7: The store holds 16 characters. A strobe while 16 are unread drops the byte and sets `ovf_sticky`. The flag stays set until reset, and the dropped byte is never delivered.
- R8: `status_word` bit 9 is `buf_empty`, bit 8 is `rd_done`, and bits 7:0 are `rd_byte`.
- R9: `buf_empty` returns to 1 exactly when every stored character has been read. It does not fall without a strobe.
- R10: Strobes on consecutive cycles, and strobes that coincide with reads, lose no character while the store is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Decoded character from the front end |
| in_stb | input | 1 | One-cycle strobe qualifying `in_byte` |
| rd_req | input | 1 | Host read request, level (valid) |
| rd_done | output | 1 | Read complete; character is on `rd_byte` |
| rd_byte | output | 8 | Character handed to the host |
| buf_empty | output | 1 | 1 when read and write pointers are equal |
| ovf_sticky | output | 1 | Set when a character was dropped on a full store |
| status_word | output | 10 | {buf_empty, rd_done, rd_byte} |

## Verification
The bench sends isolated characters and reads them one by one. This pattern shows that the empty flag tracks the pointer gap and that the read handshake timing is right. It holds the request high across a new arrival, which separates a correct one-per-request read from one that consumes again on a level. A read raised on an empty store, followed by a late arrival, exercises the waiting path. A burst on every cycle, interleaved traffic, and a burst of seventeen characters then test loss under back-to-back writes, coincident reads and the full-store drop with its sticky flag.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    localparam int KBD_CHAR_W = 8;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WAIT = 2'd1,
        RD_HOLD = 2'd2
    } rd_state_t;

    typedef struct packed {
        logic                  empty;
        logic                  done;
        logic [KBD_CHAR_W-1:0] ch;
    } kbd_status_t;

    function automatic logic ptrs_full(input logic [15:0] wp, input logic [15:0] rp,
                                       input int unsigned idx_w);
        logic [15:0] mask;
        mask = (16'd1 << idx_w) - 16'd1;
        return ((wp & mask) == (rp & mask)) && (wp[idx_w] != rp[idx_w]);
    endfunction

endpackage

// File: rtl/kbd_rx_store.sv
module kbd_rx_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              ovf
);
    import kbd_rx_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              full;

    assign empty = (wptr == rptr);
    assign full  = ptrs_full(16'(wptr), 16'(rptr), IDX_W);
    assign head  = mem[rptr[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            mem[wptr[IDX_W-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else begin
            if (wr_en) begin
                if (full) ovf  <= 1'b1;
                else      wptr <= wptr + PTR_W'(1);
            end
            if (rd_adv && !empty) begin
                rptr <= rptr + PTR_W'(1);
            end
        end
    end

endmodule

// File: rtl/kbd_rx_handshake.sv
module kbd_rx_handshake #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              empty,
    input  logic [DATA_W-1:0] head,
    output logic              adv,
    output logic              done,
    output logic [DATA_W-1:0] data_q
);
    import kbd_rx_pkg::*;

    rd_state_t state;

    assign adv = req && !empty && (state == RD_IDLE || state == RD_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            done   <= 1'b0;
            data_q <= '0;
        end else begin
            case (state)
                RD_IDLE, RD_WAIT: begin
                    if (!req) begin
                        state <= RD_IDLE;
                    end else if (!empty) begin
                        data_q <= head;
                        done   <= 1'b1;
                        state  <= RD_HOLD;
                    end else begin
                        state <= RD_WAIT;
                    end
                end
                RD_HOLD: begin
                    if (!req) begin
                        done  <= 1'b0;
                        state <= RD_IDLE;
                    end
                end
                default: begin
                    done  <= 1'b0;
                    state <= RD_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [kbd_rx_pkg::KBD_CHAR_W-1:0] in_byte,
    input  logic                              in_stb,
    input  logic                              rd_req,
    output logic                              rd_done,
    output logic [kbd_rx_pkg::KBD_CHAR_W-1:0] rd_byte,
    output logic                              buf_empty,
    output logic                              ovf_sticky,
    output logic [kbd_rx_pkg::KBD_CHAR_W+1:0] status_word
);
    import kbd_rx_pkg::*;

    logic [KBD_CHAR_W-1:0] head;
    logic                  rd_adv;
    kbd_status_t           stat;

    kbd_rx_store #(.DEPTH(DEPTH), .DATA_W(KBD_CHAR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_stb),
        .wr_data (in_byte),
        .rd_adv  (rd_adv),
        .head    (head),
        .empty   (buf_empty),
        .ovf     (ovf_sticky)
    );

    kbd_rx_handshake #(.DATA_W(KBD_CHAR_W)) u_hs (
        .clk    (clk),
        .rst    (rst),
        .req    (rd_req),
        .empty  (buf_empty),
        .head   (head),
        .adv    (rd_adv),
        .done   (rd_done),
        .data_q (rd_byte)
    );

    always_comb begin
        stat.empty  = buf_empty;
        stat.done   = rd_done;
        stat.ch     = rd_byte;
        status_word = stat;
    end

endmodule

// File: rtl/kbd_rx_fifo_chk.sv
module kbd_rx_fifo_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_stb,
    input logic       rd_req,
    input logic       rd_done,
    input logic [7:0] rd_byte,
    input logic       buf_empty,
    input logic       ovf_sticky,
    input logic       rd_adv
);
    AST_DONE_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_done); // R5

    AST_NO_SECOND_TAKE: assert property (@(posedge clk) disable iff (rst)
        (rd_done && rd_req) |=> !rd_adv); // R5

    AST_TAKE_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
        rd_adv |=> rd_done); // R4

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_done && $past(rd_done)) |-> $stable(rd_byte)); // R4

    AST_DONE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_done) |-> $past(!buf_empty)); // R6

    AST_OVF_STAYS: assert property (@(posedge clk) disable iff (rst)
        ovf_sticky |=> ovf_sticky); // R7

    AST_EMPTY_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        (buf_empty && !in_stb) |=> buf_empty); // R9

endmodule

bind kbd_rx_fifo kbd_rx_fifo_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_stb     (in_stb),
    .rd_req     (rd_req),
    .rd_done    (rd_done),
    .rd_byte    (rd_byte),
    .buf_empty  (buf_empty),
    .ovf_sticky (ovf_sticky),
    .rd_adv     (rd_adv)
);

// File: tb/kbd_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module kbd_rx_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_byte = '0;
    logic       in_stb = 1'b0;
    logic       rd_req = 1'b0;
    logic       rd_done;
    logic [7:0] rd_byte;
    logic       buf_empty;
    logic       ovf_sticky;
    logic [9:0] status_word;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q [$];

    always #2.5 clk = ~clk;

    kbd_rx_fifo dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_byte     (in_byte),
        .in_stb      (in_stb),
        .rd_req      (rd_req),
        .rd_done     (rd_done),
        .rd_byte     (rd_byte),
        .buf_empty   (buf_empty),
        .ovf_sticky  (ovf_sticky),
        .status_word (status_word)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input bit keep);
        @(negedge clk);
        in_stb  = 1'b1;
        in_byte = b;
        if (keep) exp_q.push_back(b);
    endtask

    task automatic strobe_off();
        @(negedge clk);
        in_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
    endtask

    // Raise request, wait for completion, compare against scoreboard,
    // optionally hold the request for extra cycles, then release.
    task automatic read_one(input int hold);
        logic [7:0] got;
        logic [7:0] exp;
        int wait_n;
        @(negedge clk);
        rd_req = 1'b1;
        wait_n = 0;
        do begin
            @(negedge clk);
            wait_n++;
        end while (!rd_done && wait_n < 500);
        got = rd_byte;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3 unexpected character", got, 0);
        end else begin
            exp = exp_q.pop_front();
            check(got == exp, "R3 order", got, exp);
        end
        check(status_word[8] == 1'b1 && status_word[7:0] == got,
              "R8 status packing", status_word, {buf_empty, 1'b1, got});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rd_done && rd_byte == got, "R4 held output", rd_byte, got);
        end
        rd_req = 1'b0;
        @(negedge clk);
        check(rd_done == 1'b0, "R5 done drops", rd_done, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        check(buf_empty == 1'b1, "R1 empty after reset", buf_empty, 1);
        check(rd_done == 1'b0, "R1 done after reset", rd_done, 0);
        check(ovf_sticky == 1'b0, "R1 overflow after reset", ovf_sticky, 0);
        check(status_word == 10'h200, "R8 reset status word", status_word, 10'h200);

        // R2: isolated arrivals
        push_byte(8'h41, 1'b1);
        strobe_off();
        check(buf_empty == 1'b0, "R2 empty falls", buf_empty, 0);
        push_byte(8'h42, 1'b1);
        strobe_off();
        push_byte(8'h43, 1'b1);
        strobe_off();
        read_one(3);
        read_one(0);
        check(buf_empty == 1'b0, "R9 one left", buf_empty, 0);
        read_one(1);
        check(buf_empty == 1'b1, "R9 empty after last read", buf_empty, 1);

        // R5: hold request across a new arrival; it must not be consumed
        push_byte(8'h10, 1'b1);
        strobe_off();
        @(negedge clk);
        rd_req = 1'b1;
        repeat (2) @(negedge clk);
        check(rd_done && rd_byte == 8'h10, "R4 first take", rd_byte, 8'h10);
        void'(exp_q.pop_front());
        push_byte(8'h11, 1'b1);
        strobe_off();
        repeat (3) @(negedge clk);
        check(rd_byte == 8'h10, "R5 no second take", rd_byte, 8'h10);
        check(buf_empty == 1'b0, "R5 new char still stored", buf_empty, 0);
        rd_req = 1'b0;
        @(negedge clk);
        check(rd_done == 1'b0, "R5 done low", rd_done, 0);
        read_one(0);

        // R6: request on empty store waits
        @(negedge clk);
        rd_req = 1'b1;
        repeat (6) @(negedge clk);
        check(rd_done == 1'b0, "R6 withheld while empty", rd_done, 0);
        rd_req = 1'b0;
        push_byte(8'h5a, 1'b1);
        strobe_off();
        read_one(0);
        fork
            read_one(0);
            begin
                repeat (5) @(negedge clk);
                push_byte(8'h5b, 1'b1);
                strobe_off();
            end
        join
        check(buf_empty == 1'b1, "R6 store drained", buf_empty, 1);

        // R10: burst on every cycle up to full depth
        for (int i = 0; i < 16; i++) push_byte(8'h80 + 8'(i), 1'b1);
        strobe_off();
        check(ovf_sticky == 1'b0, "R10 no overflow at depth", ovf_sticky, 0);
        for (int i = 0; i < 16; i++) read_one(0);
        check(buf_empty == 1'b1, "R10 burst drained", buf_empty, 1);

        // R10: concurrent writer and reader
        fork
            for (int i = 0; i < 30; i++) begin
                push_byte(8'hc0 ^ 8'(i * 7), 1'b1);
                strobe_off();
                @(negedge clk);
            end
            for (int i = 0; i < 30; i++) read_one(0);
        join
        check(buf_empty == 1'b1 && exp_q.size() == 0, "R10 interleaved all delivered",
              exp_q.size(), 0);

        // R7: overflow
        for (int i = 0; i < 16; i++) push_byte(8'h20 + 8'(i), 1'b1);
        push_byte(8'hee, 1'b0);
        strobe_off();
        check(ovf_sticky == 1'b1, "R7 overflow set", ovf_sticky, 1);
        for (int i = 0; i < 16; i++) read_one(0);
        check(buf_empty == 1'b1, "R7 dropped byte not stored", buf_empty, 1);
        check(ovf_sticky == 1'b1, "R7 overflow sticky", ovf_sticky, 1);
        do_reset();
        @(negedge clk);
        check(ovf_sticky == 1'b0 && buf_empty == 1'b1, "R1 reset clears overflow",
              ovf_sticky, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule